// File: doc/BRIEF.md
# Pixel format unpacker

The unpacker sits between a frame-buffer word fetcher and a palette or colour pipeline. It accepts 32-bit words on a valid/ready input, splits each word into pixels according to the configured bits-per-pixel mode, and presents the pixels one at a time on a valid/ready output. Modes of 8 bits per pixel and narrower give palette indices. The 12-, 16- and 32-bit modes give direct colour, expanded to 8 bits per channel and packed red, green, blue from the most significant byte down. A flag on every pixel tells the consumer which kind it is.

Three control inputs shape the decoding: a red/blue swap, a whole-word big-endian ordering and a within-byte reversed pixel ordering. A 2-bit format select input and a variant strap decide how 16-bit data is read. On the base variant the 2-bit select chooses 5551 or 565, and one of its codes forces a red/blue swap. On the later variant the mode code alone chooses between 5551, 565 and 4:4:4. From the configured line width and mode the block also reports the byte length of one line. Configuration is static while words are in flight.

Top module: `pix_unpack`

## Requirements
- R1: After reset, out_valid is low and in_ready is high. out_valid only rises in the cycle after a word was accepted.
- R2: A word accepted at a clock edge shows its first pixel after that edge. Each word gives 32/b pixels, where b is the element size: 1, 2, 4, 8, 16 or 32 bits for modes 0 to 5, and 16 bits for modes 6 and 7. While out_valid is high and out_ready is low, out_pix and out_direct hold still and in_ready is low. A new word can be taken in the same cycle the last pixel of the previous word leaves, so no pixels are lost or repeated.
- R3: With ordering inputs both low, pixel k of a word is bits [k*b +: b]. In modes 0 to 3 (1, 2, 4 and 8 bpp) that value appears zero-extended in out_pix[7:0], out_pix[23:8] is zero and out_direct is 0.
- R4: With cfg_be_byte high, pixel k is bits [32-(k+1)*b +: b], so the most significant element comes first. This takes priority over cfg_be_pix.
- R5: With only cfg_be_pix high and b below 8, bytes are still taken from least significant up, but inside each byte the most significant element comes first. For b of 8 or more this input has no effect.
- R6: In mode 5 (32 bpp), byte 0 of the word is the low channel, byte 1 is green, byte 2 is the high channel and byte 3 is ignored. out_direct is 1 and out_pix = {red, green, blue}. Red is the low channel when cfg_bgr is 0 and the high channel when cfg_bgr is 1.
- R7: On the later variant (var_later=1), mode 4 decodes each halfword as 5551: bits [4:0] low channel, [9:5] green, [14:10] high channel, bit 15 ignored. Mode 6 decodes 565: [4:0], [10:5], [15:11]. Both honour cfg_bgr and ignore fmt_mux. A 5-bit channel x widens to {x, x[4:2]} and a 6-bit one to {x, x[5:4]}.
- R8: On the later variant, mode 7 decodes 4:4:4 from each halfword: [3:0] low channel, [7:4] green, [11:8] high channel, bits [15:12] ignored. Each nibble n widens to {n, n}. cfg_bgr is honoured.
- R9: On the base variant in mode 4, fmt_mux=1 decodes 5551 and honours cfg_bgr. fmt_mux=0 and fmt_mux=2 decode 565 and honour cfg_bgr. fmt_mux=3 decodes 565 with red as the high channel whatever cfg_bgr is.
- R10: On the base variant, mode codes 6 and 7 decode exactly as mode 4 does under the same fmt_mux and cfg_bgr.
- R11: One cycle after cfg_mode and cfg_width are applied, line_bytes equals width/8, width/4 or width/2 for modes 0, 1 and 2 (rounded down). It equals width for mode 3, width*2 for modes 4, 6 and 7, and width*4 for mode 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| var_later | input | 1 | Variant strap: 1 selects the later variant's 16-bit decoding |
| cfg_mode | input | 3 | Bits-per-pixel mode code 0..7 |
| cfg_bgr | input | 1 | Red/blue channel swap |
| cfg_be_byte | input | 1 | Whole-word big-endian element order (wins over cfg_be_pix) |
| cfg_be_pix | input | 1 | Reversed element order inside each byte |
| fmt_mux | input | 2 | Base-variant 16-bit format select |
| cfg_width | input | WIDTH_W | Line width in pixels |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Frame-buffer word |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer takes the pixel |
| out_pix | output | 24 | Palette index in [7:0], or {red, green, blue} |
| out_direct | output | 1 | 1 for direct colour, 0 for palette index |
| line_bytes | output | WIDTH_W+2 | Bytes per line for the current mode and width |

## Verification
The hardest situation to reach is the handoff cycle. Here the last pixel of one word leaves under backpressure while the next word is already waiting. The unpacker must take the new word in the same edge without dropping or repeating a pixel. The stimulus gets there by driving words back to back while out_ready is toggled pseudo-randomly for most of the run. This places stalls on first, middle and last pixels across the 32-pixel, 8-pixel and 1-pixel word shapes. Each ordering and 16-bit interpretation is also run with channel values that are asymmetric, so a wrong swap or a shifted field cannot pass.

// File: rtl/pix_pkg.sv
package pix_pkg;

    localparam int WORD_W = 32;
    localparam int POS_W  = $clog2(WORD_W);
    localparam int CH_W   = 8;
    localparam int PIX_W  = 3 * CH_W;
    localparam int LG_W   = 3;

    typedef enum logic [2:0] {
        PM_1B  = 3'd0,
        PM_2B  = 3'd1,
        PM_4B  = 3'd2,
        PM_8B  = 3'd3,
        PM_16B = 3'd4,
        PM_32B = 3'd5,
        PM_565 = 3'd6,
        PM_12B = 3'd7
    } pix_mode_e;

    typedef enum logic [2:0] {
        CF_INDEX,
        CF_5551,
        CF_565,
        CF_444,
        CF_888
    } col_fmt_e;

    typedef struct packed {
        logic [LG_W-1:0] lg;    // log2 of element size in bits
        col_fmt_e        fmt;
        logic            swap;  // red taken from the high channel
    } decode_t;

    function automatic logic [CH_W-1:0] widen5(input logic [4:0] x);
        return {x, x[4:2]};
    endfunction

    function automatic logic [CH_W-1:0] widen6(input logic [5:0] x);
        return {x, x[5:4]};
    endfunction

    function automatic logic [CH_W-1:0] widen4(input logic [3:0] x);
        return {x, x};
    endfunction

    // Mode / variant / select pins to element size and colour format.
    function automatic decode_t pick_format(input pix_mode_e m, input logic later,
                                            input logic bgr, input logic [1:0] sel);
        decode_t d;
        d.lg   = 3'd4;
        d.fmt  = CF_INDEX;
        d.swap = bgr;
        case (m)
            PM_1B:  d.lg = 3'd0;
            PM_2B:  d.lg = 3'd1;
            PM_4B:  d.lg = 3'd2;
            PM_8B:  d.lg = 3'd3;
            PM_32B: begin
                d.lg  = 3'd5;
                d.fmt = CF_888;
            end
            default: begin
                d.lg = 3'd4;
                if (later) begin
                    case (m)
                        PM_16B:  d.fmt = CF_5551;
                        PM_565:  d.fmt = CF_565;
                        default: d.fmt = CF_444;
                    endcase
                end else begin
                    case (sel)
                        2'd1:    d.fmt = CF_5551;
                        2'd3: begin
                            d.fmt  = CF_565;
                            d.swap = 1'b1;
                        end
                        default: d.fmt = CF_565;
                    endcase
                end
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pix_slot_pick.sv
module pix_slot_pick
    import pix_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [LG_W-1:0]   lg,
    input  logic [POS_W-1:0]  idx,
    input  logic              be_byte,
    input  logic              be_pix,
    output logic [WORD_W-1:0] elem
);

    logic [POS_W-1:0]  start;
    logic [POS_W-1:0]  low_mask;
    logic [POS_W-1:0]  pos;
    logic [WORD_W-1:0] field_mask;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        // bit offset of slot idx in little-endian order (idx < 32 >> lg)
        start    = idx << lg;
        low_mask = POS_W'((1 << lg) - 1);
        if (be_byte) begin
            // mirror the whole word, keep element alignment
            pos = ~start & ~low_mask;
        end else if (be_pix) begin
            // mirror inside a byte only; zero effect for 8-bit and wider
            pos = start ^ (POS_W'(7) & ~low_mask);
        end else begin
            pos = start;
        end
        shifted = word >> pos;
        if (lg >= LG_W'(POS_W)) begin
            field_mask = '1;
        end else begin
            field_mask = (WORD_W'(1) << (1 << lg)) - WORD_W'(1);
        end
        elem = shifted & field_mask;
    end

endmodule

// File: rtl/pix_color_map.sv
module pix_color_map
    import pix_pkg::*;
(
    input  logic [WORD_W-1:0] elem,
    input  col_fmt_e          fmt,
    input  logic              swap,
    output logic [PIX_W-1:0]  rgb
);

    logic [CH_W-1:0] ch_lo;
    logic [CH_W-1:0] ch_mid;
    logic [CH_W-1:0] ch_hi;
    logic [CH_W-1:0] red;
    logic [CH_W-1:0] blue;
    logic            unused_top;

    assign unused_top = ^elem[WORD_W-1:PIX_W];

    always_comb begin
        case (fmt)
            CF_5551: begin
                ch_lo  = widen5(elem[4:0]);
                ch_mid = widen5(elem[9:5]);
                ch_hi  = widen5(elem[14:10]);
            end
            CF_565: begin
                ch_lo  = widen5(elem[4:0]);
                ch_mid = widen6(elem[10:5]);
                ch_hi  = widen5(elem[15:11]);
            end
            CF_444: begin
                ch_lo  = widen4(elem[3:0]);
                ch_mid = widen4(elem[7:4]);
                ch_hi  = widen4(elem[11:8]);
            end
            CF_888: begin
                ch_lo  = elem[7:0];
                ch_mid = elem[15:8];
                ch_hi  = elem[23:16];
            end
            default: begin
                ch_lo  = '0;
                ch_mid = '0;
                ch_hi  = '0;
            end
        endcase
        red  = swap ? ch_hi : ch_lo;
        blue = swap ? ch_lo : ch_hi;
        rgb  = {red, ch_mid, blue};
    end

endmodule

// File: rtl/pix_line_len.sv
module pix_line_len
    import pix_pkg::*;
#(
    parameter int WIDTH_W = 12
) (
    input  logic [2:0]         mode,
    input  logic [WIDTH_W-1:0] width,
    output logic [WIDTH_W+1:0] bytes_per_line
);

    localparam int LB_W = WIDTH_W + 2;

    logic [LB_W-1:0] w_ext;

    assign w_ext = LB_W'(width);

    always_comb begin
        case (pix_mode_e'(mode))
            PM_1B:   bytes_per_line = w_ext >> 3;
            PM_2B:   bytes_per_line = w_ext >> 2;
            PM_4B:   bytes_per_line = w_ext >> 1;
            PM_8B:   bytes_per_line = w_ext;
            PM_32B:  bytes_per_line = w_ext << 2;
            default: bytes_per_line = w_ext << 1;
        endcase
    end

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
    import pix_pkg::*;
#(
    parameter int WIDTH_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               var_later,
    input  logic [2:0]         cfg_mode,
    input  logic               cfg_bgr,
    input  logic               cfg_be_byte,
    input  logic               cfg_be_pix,
    input  logic [1:0]         fmt_mux,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [31:0]        in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [23:0]        out_pix,
    output logic               out_direct,
    output logic [WIDTH_W+1:0] line_bytes
);

    localparam int LB_W = WIDTH_W + 2;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [POS_W-1:0]  cnt;
        logic              full;
        logic [LB_W-1:0]   lbytes;
    } state_t;

    state_t st_d;
    state_t st_q;

    decode_t           dec;
    logic [POS_W-1:0]  last_idx;
    logic              at_last;
    logic [WORD_W-1:0] elem;
    logic [PIX_W-1:0]  rgb;
    logic [LB_W-1:0]   lb_calc;

    assign dec      = pick_format(pix_mode_e'(cfg_mode), var_later, cfg_bgr, fmt_mux);
    assign last_idx = POS_W'((WORD_W >> dec.lg) - 1);
    assign at_last  = (st_q.cnt == last_idx);

    pix_slot_pick u_pick (
        .word    (st_q.word),
        .lg      (dec.lg),
        .idx     (st_q.cnt),
        .be_byte (cfg_be_byte),
        .be_pix  (cfg_be_pix),
        .elem    (elem)
    );

    pix_color_map u_color (
        .elem (elem),
        .fmt  (dec.fmt),
        .swap (dec.swap),
        .rgb  (rgb)
    );

    pix_line_len #(.WIDTH_W(WIDTH_W)) u_len (
        .mode           (cfg_mode),
        .width          (cfg_width),
        .bytes_per_line (lb_calc)
    );

    assign in_ready   = !st_q.full || (out_ready && at_last);
    assign out_valid  = st_q.full;
    assign out_direct = (dec.fmt != CF_INDEX);
    assign out_pix    = out_direct ? rgb : {16'h0000, elem[7:0]};
    assign line_bytes = st_q.lbytes;

    always_comb begin
        st_d        = st_q;
        st_d.lbytes = lb_calc;
        if (in_valid && in_ready) begin
            st_d.word = in_data;
            st_d.cnt  = '0;
            st_d.full = 1'b1;
        end else if (st_q.full && out_ready) begin
            if (at_last) begin
                st_d.full = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: a stalled pixel must not move
    a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_direct)));

    // R2: no new word while a pixel is stalled
    a_r2_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R1: output only starts after an accepted word
    a_r1_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid));

    // R3: indices never carry bits above the low byte
    a_r3_index_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_direct) |-> (out_pix[23:8] == 16'h0000));

    // R6: 32-bit mode is always direct colour
    a_r6_wide_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_mode == 3'd5) |-> out_direct);

    // R11: 8 bpp line length equals width
    a_r11_bytes_8bpp: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 3'd3) |=> (line_bytes == {2'b00, $past(cfg_width)}));

    // R11: 32 bpp line length is four times width
    a_r11_bytes_32bpp: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 3'd5) |=> (line_bytes == {$past(cfg_width), 2'b00}));

endmodule

// File: tb/sim_pix_unpack.sv
module sim_pix_unpack;

    localparam int WIDTH_W = 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               var_later = 1'b0;
    logic [2:0]         cfg_mode = 3'd3;
    logic               cfg_bgr = 1'b0;
    logic               cfg_be_byte = 1'b0;
    logic               cfg_be_pix = 1'b0;
    logic [1:0]         fmt_mux = 2'd0;
    logic [WIDTH_W-1:0] cfg_width = '0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [31:0]        in_data = '0;
    logic               out_valid;
    logic               out_ready = 1'b1;
    logic [23:0]        out_pix;
    logic               out_direct;
    logic [WIDTH_W+1:0] line_bytes;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  bp_on    = 1'b0;

    typedef struct {
        logic [23:0] pix;
        logic        dir;
        string       tag;
    } exp_t;

    exp_t sb[$];

    pix_unpack #(.WIDTH_W(WIDTH_W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .var_later   (var_later),
        .cfg_mode    (cfg_mode),
        .cfg_bgr     (cfg_bgr),
        .cfg_be_byte (cfg_be_byte),
        .cfg_be_pix  (cfg_be_pix),
        .fmt_mux     (fmt_mux),
        .cfg_width   (cfg_width),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_pix     (out_pix),
        .out_direct  (out_direct),
        .line_bytes  (line_bytes)
    );

    always #10 clk = ~clk;

    // consumer backpressure, changed well after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
        end
    end

    function automatic int wid5(input int x);
        return x * 8 + x / 4;
    endfunction
    function automatic int wid6(input int x);
        return x * 4 + x / 16;
    endfunction

    // Independent model: expected pixels of one word under current settings.
    task automatic model_push(input logic [31:0] w, input string tag);
        int b, n, pos, ppb, fmt, lo, mid, hi;
        bit swp;
        logic [63:0] e;
        exp_t it;
        swp = cfg_bgr;
        fmt = 0;
        if (cfg_mode <= 3) begin
            b = 1 << cfg_mode;
        end else if (cfg_mode == 5) begin
            b = 32; fmt = 4;
        end else begin
            b = 16;
            if (var_later) begin
                fmt = (cfg_mode == 4) ? 1 : (cfg_mode == 6) ? 2 : 3;
            end else if (fmt_mux == 2'd1) begin
                fmt = 1;
            end else if (fmt_mux == 2'd3) begin
                fmt = 2; swp = 1'b1;
            end else begin
                fmt = 2;
            end
        end
        n = 32 / b;
        for (int k = 0; k < n; k++) begin
            if (cfg_be_byte) begin
                pos = 32 - (k + 1) * b;
            end else if (cfg_be_pix && b < 8) begin
                ppb = 8 / b;
                pos = (k / ppb) * 8 + (ppb - 1 - (k % ppb)) * b;
            end else begin
                pos = k * b;
            end
            e = ({32'h0, w} >> pos) & ((64'd1 << b) - 64'd1);
            it.tag = tag;
            if (fmt == 0) begin
                it.dir = 1'b0;
                it.pix = {16'h0000, e[7:0]};
            end else begin
                case (fmt)
                    1: begin lo = wid5(int'(e[4:0])); mid = wid5(int'(e[9:5])); hi = wid5(int'(e[14:10])); end
                    2: begin lo = wid5(int'(e[4:0])); mid = wid6(int'(e[10:5])); hi = wid5(int'(e[15:11])); end
                    3: begin lo = int'(e[3:0]) * 17; mid = int'(e[7:4]) * 17; hi = int'(e[11:8]) * 17; end
                    default: begin lo = int'(e[7:0]); mid = int'(e[15:8]); hi = int'(e[23:16]); end
                endcase
                it.dir = 1'b1;
                if (swp) it.pix = {hi[7:0], mid[7:0], lo[7:0]};
                else     it.pix = {lo[7:0], mid[7:0], hi[7:0]};
            end
            sb.push_back(it);
        end
    endtask

    task automatic send(input logic [31:0] w, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        model_push(w, tag);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (sb.size() != 0 || out_valid) @(negedge clk);
    endtask

    task automatic set_cfg(input logic later, input logic [2:0] mode, input logic bgr,
                           input logic beb, input logic bep, input logic [1:0] mux);
        drain();
        var_later   = later;
        cfg_mode    = mode;
        cfg_bgr     = bgr;
        cfg_be_byte = beb;
        cfg_be_pix  = bep;
        fmt_mux     = mux;
    endtask

    task automatic check_len(input logic [2:0] mode, input int width, input int expv);
        @(negedge clk);
        cfg_mode  = mode;
        cfg_width = WIDTH_W'(width);
        @(negedge clk);
        n_checks++;
        if (int'(line_bytes) != expv) begin
            n_fails++;
            $display("FAIL R11 line_bytes mode=%0d width=%0d actual=%0d expected=%0d",
                     mode, width, line_bytes, expv);
        end
    endtask

    // monitor / scoreboard
    bit          hold_pend = 1'b0;
    logic [23:0] hold_pix;
    logic        hold_dir;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend) begin
                n_checks++;
                if (!(out_valid && out_pix == hold_pix && out_direct == hold_dir)) begin
                    n_fails++;
                    $display("FAIL R2 stall hold actual=%h/%b expected=%h/%b",
                             out_pix, out_direct, hold_pix, hold_dir);
                end
            end
            hold_pend = out_valid && !out_ready;
            hold_pix  = out_pix;
            hold_dir  = out_direct;
            if (out_valid && out_ready) begin
                if (sb.size() == 0) begin
                    n_checks++;
                    n_fails++;
                    $display("FAIL R2 extra pixel actual=%h expected=none", out_pix);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    n_checks++;
                    if (out_pix != it.pix || out_direct != it.dir) begin
                        n_fails++;
                        $display("FAIL %s pixel actual=%h/%b expected=%h/%b",
                                 it.tag, out_pix, out_direct, it.pix, it.dir);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        n_checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_fails++;
            $display("FAIL R1 reset actual=%b/%b expected=0/1", out_valid, in_ready);
        end

        // R3: little-endian index modes, no backpressure first
        set_cfg(1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 2'd0);
        send(32'h44332211, "R3");
        send(32'hA5C30FF0, "R3");
        bp_on = 1'b1;
        set_cfg(1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 2'd0);
        send(32'h76543210, "R3");
        send(32'hFEDCBA98, "R3");
        set_cfg(1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0);
        send(32'hE4E41B1B, "R3");
        set_cfg(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0);
        send(32'h80000001, "R3");
        send(32'h5A0F33C6, "R3");

        // R4: whole-word big-endian, and its priority over pixel reversal
        set_cfg(1'b0, 3'd3, 1'b0, 1'b1, 1'b0, 2'd0);
        send(32'h44332211, "R4");
        set_cfg(1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 2'd0);
        send(32'h80000003, "R4");
        set_cfg(1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 2'd0);
        send(32'h76543210, "R4");
        set_cfg(1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 2'd1);
        send(32'h12348421, "R4");

        // R5: reversed pixels inside each byte
        set_cfg(1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 2'd0);
        send(32'h76543210, "R5");
        set_cfg(1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 2'd0);
        send(32'h1B1BE4E4, "R5");
        set_cfg(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0);
        send(32'h00000180, "R5");
        set_cfg(1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 2'd0);
        send(32'h44332211, "R5");

        // R6: 32 bpp direct colour
        set_cfg(1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 2'd0);
        send(32'hFF112233, "R6");
        send(32'h00C08040, "R6");
        set_cfg(1'b0, 3'd5, 1'b1, 1'b0, 1'b0, 2'd0);
        send(32'hFF112233, "R6");

        // R7: later variant 5551 and 565, select pin ignored
        set_cfg(1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 2'd3);
        send(32'hFC1F83E1, "R7");
        set_cfg(1'b1, 3'd4, 1'b1, 1'b0, 1'b0, 2'd0);
        send(32'h7C0F1234, "R7");
        set_cfg(1'b1, 3'd6, 1'b0, 1'b0, 1'b0, 2'd1);
        send(32'hF81F07E3, "R7");
        set_cfg(1'b1, 3'd6, 1'b1, 1'b0, 1'b0, 2'd3);
        send(32'h1234ABCD, "R7");

        // R8: later variant 4:4:4
        set_cfg(1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 2'd0);
        send(32'hF1230ABC, "R8");
        set_cfg(1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 2'd0);
        send(32'hF1230ABC, "R8");

        // R9: base variant 16-bit select codes
        for (int mx = 0; mx < 4; mx++) begin
            for (int bg = 0; bg < 2; bg++) begin
                set_cfg(1'b0, 3'd4, bg[0], 1'b0, 1'b0, mx[1:0]);
                send(32'h1234ABCD, "R9");
                send(32'hF81F8421, "R9");
            end
        end

        // R10: base variant codes 6 and 7 follow mode 4
        set_cfg(1'b0, 3'd6, 1'b0, 1'b0, 1'b0, 2'd1);
        send(32'h1234ABCD, "R10");
        set_cfg(1'b0, 3'd7, 1'b1, 1'b0, 1'b0, 2'd3);
        send(32'hF81F8421, "R10");
        set_cfg(1'b0, 3'd7, 1'b1, 1'b0, 1'b0, 2'd2);
        send(32'hF81F8421, "R10");

        // R2: back-to-back words across word shapes under backpressure
        set_cfg(1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 2'd0);
        for (int i = 0; i < 6; i++) send(32'h01020304 * (i + 1), "R2");
        set_cfg(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0);
        for (int i = 0; i < 3; i++) send(32'h9E3779B9 ^ (i * 32'h1111), "R2");
        drain();
        n_checks++;
        if (sb.size() != 0) begin
            n_fails++;
            $display("FAIL R2 pixels missing actual=%0d expected=0", sb.size());
        end

        // R11: bytes per line
        check_len(3'd0, 320, 40);
        check_len(3'd1, 320, 80);
        check_len(3'd2, 320, 160);
        check_len(3'd3, 320, 320);
        check_len(3'd4, 320, 640);
        check_len(3'd5, 320, 1280);
        check_len(3'd6, 320, 640);
        check_len(3'd7, 320, 640);
        check_len(3'd0, 1003, 125);
        check_len(3'd5, 4095, 16380);

        finish_run();
    end

endmodule